// File: doc/BRIEF.md
# Two-Window PPM Energy Demodulator

This block sits behind the energy detector of an impulse-radio receiver. For every symbol slot the synchronizer strobes in two integrated energy readings from a 4-bit ADC: one for the early half of the slot and one for the late half. The block decides the binary pulse-position symbol by checking which half held more energy. Once the synchronizer reports lock, the block feeds the decided bits through a 16-bit delimiter matcher.

After the delimiter is found, the next eight bits give the number of payload bytes. The block then assembles exactly that many bytes and presents each one with a valid flag. The first byte is marked as the start of the frame. The last byte is marked as the end of the frame, and the block then goes back to hunting for the next delimiter.

All outputs are registered, so the block can be placed directly between the synchronizer and the packet layer.

Top module: `ppm_energy_demod`

## Requirements
- R1: A symbol decides to 1 when its late-window energy (sample strobed with `win_late_i`=1) is strictly greater than its early-window energy (strobed with `win_late_i`=0); it decides to 0 otherwise, including when both energies are equal. Codes are unsigned, and 15 is full scale.
- R2: Decided bits are used only while `lock_i` is high. While `lock_i` is low, the delimiter matcher and any frame in progress are discarded and the block is back in delimiter search.
- R3: During search, when the last 16 decided bits, oldest first, equal 1110010100001010, `sfd_hit_o` pulses for one cycle. The pulse comes with no byte and no end flag.
- R4: The 8 bits that follow the delimiter, most significant bit first, form the payload length N.
- R5: The next N×8 bits are delivered as N bytes on `byte_o`, most significant bit first, each with a one-cycle `byte_vld_o`. Exactly N bytes are delivered.
- R6: `sof_o` is high together with the first payload byte only.
- R7: `eof_o` pulses for one cycle in the same cycle as the last payload byte, and the block then returns to delimiter search.
- R8: A length of 0 produces an `eof_o` pulse, with no `byte_vld_o`, in the cycle where the length byte would have been complete.
- R9: Every output event appears on the second rising clock edge, counting the edge that samples the late-window strobe of the bit that completes it as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Synchronizer lock; enables framing |
| win_stb_i | input | 1 | An energy sample is present this cycle |
| win_late_i | input | 1 | 0: early-window sample, 1: late-window sample (ends the symbol) |
| energy_i | input | 4 | Unsigned integrated energy code |
| byte_o | output | 8 | Payload byte |
| byte_vld_o | output | 1 | `byte_o` is valid this cycle |
| sof_o | output | 1 | First payload byte of the frame |
| eof_o | output | 1 | End of frame |
| sfd_hit_o | output | 1 | Delimiter matched |

## Verification
The bit decision is registered on the edge that samples the late strobe. The framer registers its result one edge later, so each byte, end flag and delimiter pulse is due two edges after the late strobe of the bit that completes it. The bench notes the cycle count at which it drives each late strobe. A monitor records the cycle at which `eof_o` is seen, sampling on falling edges, and the bench checks that the difference is exactly two. Byte contents, flag placement and counts are compared only after a short idle tail, once every result is due.

// File: rtl/ppm_demod_pkg.sv
package ppm_demod_pkg;
    localparam int EW     = 4;
    localparam int BW     = 8;
    localparam int SFD_W  = 16;
    localparam logic [SFD_W-1:0] SFD_PAT = 16'b1110_0101_0000_1010;

    typedef enum logic [1:0] {FR_HUNT, FR_LEN, FR_PAY} fr_state_t;

    typedef struct packed {
        logic [BW-1:0] data;
        logic          vld;
        logic          sof;
        logic          eof;
        logic          sfd;
    } fr_out_t;

    // late window must strictly exceed early window; ties give 0
    function automatic logic ppm_decide(input logic [EW-1:0] early,
                                        input logic [EW-1:0] late);
        return late > early;
    endfunction
endpackage

// File: rtl/ppm_window_slicer.sv
module ppm_window_slicer
    import ppm_demod_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          win_stb,
    input  logic          win_late,
    input  logic [EW-1:0] energy,
    output logic          bit_o,
    output logic          bit_vld
);
    logic [EW-1:0] early_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= '0;
            bit_o   <= 1'b0;
            bit_vld <= 1'b0;
        end else begin
            bit_vld <= 1'b0;
            if (win_stb && !win_late)
                early_q <= energy;
            if (win_stb && win_late) begin
                bit_o   <= ppm_decide(early_q, energy);
                bit_vld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ppm_frame_parser.sv
module ppm_frame_parser
    import ppm_demod_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    lock,
    input  logic    bit_i,
    input  logic    bit_vld,
    output fr_out_t fo
);
    localparam int CW = $clog2(BW);

    fr_state_t        state;
    logic [SFD_W-1:0] hunt_sr;
    logic [BW-1:0]    acc;
    logic [CW-1:0]    bcnt;
    logic [BW-1:0]    remain;
    logic             first;

    logic [SFD_W-1:0] hunt_nxt;
    logic [BW-1:0]    acc_nxt;
    logic             byte_done;

    always_comb begin
        hunt_nxt  = {hunt_sr[SFD_W-2:0], bit_i};
        acc_nxt   = {acc[BW-2:0], bit_i};
        byte_done = (bcnt == CW'(BW-1));
    end

    always_ff @(posedge clk) begin
        if (rst || !lock) begin
            state   <= FR_HUNT;
            hunt_sr <= '0;
            acc     <= '0;
            bcnt    <= '0;
            remain  <= '0;
            first   <= 1'b0;
            fo      <= '0;
        end else begin
            fo.vld <= 1'b0;
            fo.sof <= 1'b0;
            fo.eof <= 1'b0;
            fo.sfd <= 1'b0;
            if (bit_vld) begin
                unique case (state)
                    FR_HUNT: begin
                        if (hunt_nxt == SFD_PAT) begin
                            hunt_sr <= '0;
                            bcnt    <= '0;
                            fo.sfd  <= 1'b1;
                            state   <= FR_LEN;
                        end else begin
                            hunt_sr <= hunt_nxt;
                        end
                    end
                    FR_LEN: begin
                        acc  <= acc_nxt;
                        bcnt <= bcnt + 1'b1;
                        if (byte_done) begin
                            bcnt <= '0;
                            if (acc_nxt == '0) begin
                                fo.eof <= 1'b1;
                                state  <= FR_HUNT;
                            end else begin
                                remain <= acc_nxt;
                                first  <= 1'b1;
                                state  <= FR_PAY;
                            end
                        end
                    end
                    FR_PAY: begin
                        acc  <= acc_nxt;
                        bcnt <= bcnt + 1'b1;
                        if (byte_done) begin
                            bcnt    <= '0;
                            fo.data <= acc_nxt;
                            fo.vld  <= 1'b1;
                            fo.sof  <= first;
                            first   <= 1'b0;
                            remain  <= remain - 1'b1;
                            if (remain == BW'(1)) begin
                                fo.eof <= 1'b1;
                                state  <= FR_HUNT;
                            end
                        end
                    end
                    default: state <= FR_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/ppm_energy_demod.sv
module ppm_energy_demod
    import ppm_demod_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          lock_i,
    input  logic          win_stb_i,
    input  logic          win_late_i,
    input  logic [EW-1:0] energy_i,
    output logic [BW-1:0] byte_o,
    output logic          byte_vld_o,
    output logic          sof_o,
    output logic          eof_o,
    output logic          sfd_hit_o
);
    logic    sym_bit;
    logic    bit_vld;
    fr_out_t fo;

    ppm_window_slicer u_slice (
        .clk      (clk),
        .rst      (rst),
        .win_stb  (win_stb_i),
        .win_late (win_late_i),
        .energy   (energy_i),
        .bit_o    (sym_bit),
        .bit_vld  (bit_vld)
    );

    ppm_frame_parser u_frame (
        .clk     (clk),
        .rst     (rst),
        .lock    (lock_i),
        .bit_i   (sym_bit),
        .bit_vld (bit_vld),
        .fo      (fo)
    );

    assign byte_o     = fo.data;
    assign byte_vld_o = fo.vld;
    assign sof_o      = fo.sof;
    assign eof_o      = fo.eof;
    assign sfd_hit_o  = fo.sfd;
endmodule

// File: rtl/ppm_demod_chk.sv
module ppm_demod_chk (
    input logic clk,
    input logic rst,
    input logic lock_i,
    input logic bit_vld,
    input logic byte_vld_o,
    input logic sof_o,
    input logic eof_o,
    input logic sfd_hit_o
);
    // R6
    sof_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
        sof_o |-> byte_vld_o);

    // R7
    eof_single_chk: assert property (@(posedge clk) disable iff (rst)
        eof_o |=> !eof_o);

    // R9
    out_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_vld_o || eof_o || sfd_hit_o) |-> $past(bit_vld));

    // R2
    sfd_locked_chk: assert property (@(posedge clk) disable iff (rst)
        sfd_hit_o |-> $past(lock_i));

    // R3
    sfd_alone_chk: assert property (@(posedge clk) disable iff (rst)
        sfd_hit_o |-> (!byte_vld_o && !eof_o));
endmodule

bind ppm_energy_demod ppm_demod_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lock_i     (lock_i),
    .bit_vld    (bit_vld),
    .byte_vld_o (byte_vld_o),
    .sof_o      (sof_o),
    .eof_o      (eof_o),
    .sfd_hit_o  (sfd_hit_o)
);

// File: tb/sim_ppm_energy_demod.sv
`timescale 1ns/1ps
module sim_ppm_energy_demod;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lock_i = 1'b0;
    logic       win_stb_i = 1'b0;
    logic       win_late_i = 1'b0;
    logic [3:0] energy_i = '0;
    logic [7:0] byte_o;
    logic       byte_vld_o, sof_o, eof_o, sfd_hit_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] got [0:255];
    bit         got_sof [0:255];
    logic [7:0] exp_b [0:255];
    int n_got, n_eof, n_sfd, n_sof, eof_cyc, last_late;
    bit eof_byte;

    localparam logic [15:0] DELIM = 16'b1110_0101_0000_1010;

    ppm_energy_demod u0 (
        .clk(clk), .rst(rst), .lock_i(lock_i), .win_stb_i(win_stb_i),
        .win_late_i(win_late_i), .energy_i(energy_i), .byte_o(byte_o),
        .byte_vld_o(byte_vld_o), .sof_o(sof_o), .eof_o(eof_o), .sfd_hit_o(sfd_hit_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld_o) begin
                got[n_got[7:0]]     = byte_o;
                got_sof[n_got[7:0]] = sof_o;
                n_got++;
            end
            if (sof_o) n_sof++;
            if (eof_o) begin
                n_eof++;
                eof_cyc  = cyc;
                eof_byte = byte_vld_o;
            end
            if (sfd_hit_o) n_sfd++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clear_mon();
        n_got = 0; n_eof = 0; n_sfd = 0; n_sof = 0; eof_cyc = -1; eof_byte = 0;
    endtask

    // mode 0: energies with margin for bit b; mode 1: equal energies
    task automatic send_bit(input bit b, input int mode);
        logic [3:0] e_early, e_late;
        if (mode == 1) begin
            e_early = 4'($urandom % 16);
            e_late  = e_early;
        end else if (b) begin
            e_early = 4'($urandom % 15);
            e_late  = e_early + 4'd1 + 4'($urandom % (15 - int'(e_early)));
        end else begin
            e_late  = 4'($urandom % 16);
            e_early = e_late + 4'($urandom % (16 - int'(e_late)));
        end
        @(negedge clk);
        win_stb_i = 1'b1; win_late_i = 1'b0; energy_i = e_early;
        @(negedge clk);
        win_late_i = 1'b1; energy_i = e_late; last_late = cyc;
        @(negedge clk);
        win_stb_i = 1'b0; win_late_i = 1'b0;
        repeat ($urandom % 2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input int mode);
        for (int i = 7; i >= 0; i--) send_bit(v[i], mode);
    endtask

    task automatic send_head(input int len);
        for (int i = 0; i < 32; i++) send_bit(1'b0, 0);
        for (int i = 15; i >= 0; i--) send_bit(DELIM[i], 0);
        send_byte(8'(len), 0);
    endtask

    // pmode 1: payload sent with tied energies, expected all zero (R1)
    task automatic run_frame(input int len, input int pmode);
        clear_mon();
        for (int k = 0; k < len; k++) exp_b[k] = (pmode == 1) ? 8'h00 : 8'($urandom);
        send_head(len);
        for (int k = 0; k < len; k++) send_byte(exp_b[k], pmode);
        repeat (4) @(negedge clk);
        chk(n_sfd == 1, "R3", "delimiter pulses", n_sfd, 1);
        chk(n_got == len, "R4/R5", "payload byte count", n_got, len);
        for (int k = 0; k < len && k < n_got; k++)
            chk(got[k] == exp_b[k], (pmode == 1) ? "R1" : "R5", "payload byte",
                int'(got[k]), int'(exp_b[k]));
        chk(n_sof == (len > 0 ? 1 : 0), "R6", "start flag count", n_sof, len > 0 ? 1 : 0);
        if (len > 0 && n_got > 0)
            chk(got_sof[0] == 1'b1, "R6", "start on first byte", int'(got_sof[0]), 1);
        chk(n_eof == 1, (len == 0) ? "R8" : "R7", "end flag count", n_eof, 1);
        chk(eof_byte == (len > 0), (len == 0) ? "R8" : "R7", "end with last byte",
            int'(eof_byte), int'(len > 0));
        chk(eof_cyc == last_late + 2, "R9", "end flag latency", eof_cyc - last_late, 2);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        clear_mon();
        repeat (3) @(negedge clk);
        chk({byte_vld_o, sof_o, eof_o, sfd_hit_o} == 4'b0, "R5", "outputs in reset",
            int'({byte_vld_o, sof_o, eof_o, sfd_hit_o}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: no lock, full frame ignored
        clear_mon();
        send_head(3);
        for (int k = 0; k < 3; k++) send_byte(8'hA5, 0);
        repeat (4) @(negedge clk);
        chk(n_sfd == 0, "R2", "delimiter while unlocked", n_sfd, 0);
        chk(n_got == 0, "R2", "bytes while unlocked", n_got, 0);

        lock_i = 1'b1;
        run_frame(10, 0);          // R4: length ten
        run_frame(0, 0);           // R8
        run_frame(1, 0);
        run_frame(4, 1);           // R1 ties
        for (int r = 0; r < 10; r++) run_frame(1 + int'($urandom % 20), 0);

        // R2: lock lost mid-frame
        clear_mon();
        send_head(5);
        send_byte(8'h3C, 0);
        send_byte(8'hC3, 0);
        @(negedge clk); lock_i = 1'b0;
        @(negedge clk); lock_i = 1'b1;
        for (int k = 0; k < 3; k++) send_byte(8'h81, 0);
        repeat (4) @(negedge clk);
        chk(n_got == 2, "R2", "bytes before lock loss", n_got, 2);
        chk(n_eof == 0, "R2", "no end after lock loss", n_eof, 0);
        run_frame(3, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule